// File: doc/BRIEF.md
# Multi-Bank Operation Permission Controller

This block sits in the command decoder of a flash memory split into several banks. It keeps a small state for every bank (idle, programming, erasing, program-suspended, erase-suspended) and, for each incoming command, decides whether that command is accepted or rejected for the bank it targets. It enforces the read-while-write rules. Only one bank may program or erase at a time. Reads go ahead in every bank that is not busy. A busy bank must be suspended before it can be read. An erase suspension leaves room for a program in another bank. The parameter bank and the special spaces (query, one-time-programmable, identifier) may not be used at the same time.

Commands arrive as a plain strobe `cmd_valid` with a code, a bank index and a special-space flag. There is no back-pressure. The block takes one command in every cycle in which `cmd_valid` is high, and one cycle later it returns `resp_valid` together with the verdict on `resp_accept`. Program and erase are two-cycle commands: a setup followed by a confirm. A pulse on `eng_done` from the program/erase engine ends the running operation. The per-bank states are always visible on `bank_state`.

Top module: `bank_perm_ctrl`

## Requirements
- R1: After reset every bank is idle (state code 0) and `resp_valid` is low. State codes per bank are: 0 idle, 1 programming, 2 erasing, 3 program-suspended, 4 erase-suspended. Bank i occupies `bank_state[3*i+2:3*i]`.
- R2: A command presented with `cmd_valid` high yields `resp_valid` high in the next cycle, with the verdict on `resp_accept`. A cycle with `cmd_valid` low yields `resp_valid` low and changes no bank state. Command codes are: 0 read array, 1 read status, 2 read query, 3 read identifier, 4 program setup, 5 erase setup, 6 confirm, 7 suspend, 8 resume. Any other code is rejected.
- R3: At most one bank is programming or erasing at any time. A program setup or an erase setup is rejected while any bank is programming or erasing.
- R4: Read array, read query and read identifier are accepted for a bank that is neither programming nor erasing, and rejected for a bank that is. Read status is always accepted.
- R5: An accepted setup is followed by a confirm. A confirm to the same bank moves that bank to programming or erasing. A confirm with no setup outstanding, or one aimed at a different bank, is rejected. While a setup is outstanding, reads to other banks are accepted, reads to the setup bank are rejected, and further setups are rejected. A setup needs an idle target bank.
- R6: A suspend is accepted only for the bank that is programming or erasing, and moves it to program-suspended or erase-suspended. After that, array reads in that bank are accepted.
- R7: A resume on a suspended bank returns it to its earlier busy state. This holds only when no bank is busy and no setup is outstanding. A resume on a bank that is not suspended is rejected.
- R8: While a bank is erase-suspended, a program setup and confirm to another idle bank are accepted. An erase setup is rejected while any bank is suspended. A program setup is rejected while any bank is program-suspended.
- R9: A special-space access is rejected while bank 0 is programming or erasing. Special-space accesses are read query, read identifier, and read array with `cmd_special` high.
- R10: After an accepted special-space access, a program or erase setup to bank 0 is rejected. This lasts until an accepted read array with `cmd_special` low.
- R11: `eng_done` returns the programming or erasing bank to idle, and a suspended bank keeps its state. When a command arrives in the same cycle as `eng_done`, it is judged against the states after completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per high cycle |
| cmd_code | input | 4 | Command code |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank index |
| cmd_special | input | 1 | Read array targets the one-time-programmable space |
| eng_done | input | 1 | Completion pulse from the program/erase engine |
| resp_valid | output | 1 | Verdict available for the previous cycle's command |
| resp_accept | output | 1 | 1 accepted, 0 rejected |
| bank_state | output | 3*NUM_BANKS | Packed per-bank state codes |

## Verification
The bench builds the block with NUM_BANKS set to 4. With four banks, one test can hold an erase-suspended bank, a programming bank and two reading banks all at once, and the parameter bank and the highest index are both reached in a short scripted sequence. A long random phase then drives every code, including illegal ones, on all four banks. This covers same-cycle completion and command, and confirms aimed at the wrong bank.

// File: rtl/bank_perm_pkg.sv
package bank_perm_pkg;

  typedef enum logic [3:0] {
    CMD_RD_ARRAY    = 4'd0,
    CMD_RD_STATUS   = 4'd1,
    CMD_RD_QUERY    = 4'd2,
    CMD_RD_ID       = 4'd3,
    CMD_PROG_SETUP  = 4'd4,
    CMD_ERASE_SETUP = 4'd5,
    CMD_CONFIRM     = 4'd6,
    CMD_SUSPEND     = 4'd7,
    CMD_RESUME      = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE  = 3'd0,
    BK_PROG  = 3'd1,
    BK_ERASE = 3'd2,
    BK_PSUSP = 3'd3,
    BK_ESUSP = 3'd4
  } bank_st_e;

  localparam int ST_W = 3;

endpackage

// File: rtl/bank_fsm.sv
module bank_fsm
  import bank_perm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     eng_done,
  input  logic     sel,
  input  cmd_e     cmd,
  input  logic     pend_erase,
  output bank_st_e st_q,
  output bank_st_e st_eff
);

  bank_st_e st_d;

  // completion is applied first so a same-cycle command sees the idle bank
  always_comb begin
    st_eff = st_q;
    if (eng_done && (st_q == BK_PROG || st_q == BK_ERASE)) st_eff = BK_IDLE;
  end

  always_comb begin
    st_d = st_eff;
    if (sel) begin
      unique case (cmd)
        CMD_CONFIRM: st_d = pend_erase ? BK_ERASE : BK_PROG;
        CMD_SUSPEND: st_d = (st_eff == BK_ERASE) ? BK_ESUSP : BK_PSUSP;
        CMD_RESUME:  st_d = (st_eff == BK_ESUSP) ? BK_ERASE : BK_PROG;
        default:     st_d = st_eff;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= BK_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/perm_decode.sv
module perm_decode
  import bank_perm_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  bank_st_e              st [NUM_BANKS],
  input  cmd_e                  cmd,
  input  logic [BANK_W-1:0]     bank,
  input  logic                  special,
  input  logic                  pend_vld,
  input  logic [BANK_W-1:0]     pend_bank,
  input  logic                  spc_mode,
  output logic                  ok
);

  logic [NUM_BANKS-1:0] busy_v, susp_v, psusp_v;
  bank_st_e tgt;
  logic tgt_busy, tgt_susp, par_busy, is_spc, pend_hit, setup_ok;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_flags
    assign busy_v[i]  = (st[i] == BK_PROG) || (st[i] == BK_ERASE);
    assign psusp_v[i] = (st[i] == BK_PSUSP);
    assign susp_v[i]  = (st[i] == BK_PSUSP) || (st[i] == BK_ESUSP);
  end

  always_comb begin
    tgt      = st[bank];
    tgt_busy = (tgt == BK_PROG) || (tgt == BK_ERASE);
    tgt_susp = (tgt == BK_PSUSP) || (tgt == BK_ESUSP);
    par_busy = busy_v[0];
    is_spc   = (cmd == CMD_RD_QUERY) || (cmd == CMD_RD_ID) ||
               ((cmd == CMD_RD_ARRAY) && special);
    pend_hit = pend_vld && (pend_bank == bank);
    setup_ok = !(|busy_v) && !pend_vld && (tgt == BK_IDLE) &&
               !((bank == '0) && spc_mode);
    unique case (cmd)
      CMD_RD_ARRAY, CMD_RD_QUERY, CMD_RD_ID:
        ok = !tgt_busy && !pend_hit && !(is_spc && par_busy);
      CMD_RD_STATUS:   ok = 1'b1;
      CMD_PROG_SETUP:  ok = setup_ok && !(|psusp_v);
      CMD_ERASE_SETUP: ok = setup_ok && !(|susp_v);
      CMD_CONFIRM:     ok = pend_hit;
      CMD_SUSPEND:     ok = tgt_busy;
      CMD_RESUME:      ok = tgt_susp && !(|busy_v) && !pend_vld;
      default:         ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/bank_perm_ctrl.sv
module bank_perm_ctrl
  import bank_perm_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [3:0]                cmd_code,
  input  logic [BANK_W-1:0]         cmd_bank,
  input  logic                      cmd_special,
  input  logic                      eng_done,
  output logic                      resp_valid,
  output logic                      resp_accept,
  output logic [ST_W*NUM_BANKS-1:0] bank_state
);

  cmd_e     cmd;
  bank_st_e st_q   [NUM_BANKS];
  bank_st_e st_eff [NUM_BANKS];
  logic     dec_ok, acc;
  logic     pend_vld, pend_erase, spc_mode;
  logic [BANK_W-1:0] pend_bank;
  logic     is_spc;

  assign cmd    = cmd_e'(cmd_code);
  assign acc    = cmd_valid && dec_ok;
  assign is_spc = (cmd == CMD_RD_QUERY) || (cmd == CMD_RD_ID) ||
                  ((cmd == CMD_RD_ARRAY) && cmd_special);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    bank_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .eng_done   (eng_done),
      .sel        (acc && (cmd_bank == BANK_W'(i))),
      .cmd        (cmd),
      .pend_erase (pend_erase),
      .st_q       (st_q[i]),
      .st_eff     (st_eff[i])
    );
    assign bank_state[ST_W*i +: ST_W] = st_q[i];
  end

  perm_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .st        (st_eff),
    .cmd       (cmd),
    .bank      (cmd_bank),
    .special   (cmd_special),
    .pend_vld  (pend_vld),
    .pend_bank (pend_bank),
    .spc_mode  (spc_mode),
    .ok        (dec_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld    <= 1'b0;
      pend_erase  <= 1'b0;
      pend_bank   <= '0;
      spc_mode    <= 1'b0;
      resp_valid  <= 1'b0;
      resp_accept <= 1'b0;
    end else begin
      resp_valid  <= cmd_valid;
      resp_accept <= acc;
      if (acc) begin
        if (cmd == CMD_PROG_SETUP || cmd == CMD_ERASE_SETUP) begin
          pend_vld   <= 1'b1;
          pend_erase <= (cmd == CMD_ERASE_SETUP);
          pend_bank  <= cmd_bank;
        end else if (cmd == CMD_CONFIRM) begin
          pend_vld <= 1'b0;
        end
        if (is_spc) spc_mode <= 1'b1;
        else if (cmd == CMD_RD_ARRAY) spc_mode <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bank_perm_chk.sv
module bank_perm_chk
  import bank_perm_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmd_valid,
  input logic [3:0]                cmd_code,
  input logic [BANK_W-1:0]         cmd_bank,
  input logic                      eng_done,
  input logic                      resp_valid,
  input logic                      resp_accept,
  input logic [ST_W*NUM_BANKS-1:0] bank_state
);

  logic [3:0]        last_cmd;
  logic [BANK_W-1:0] last_bank;
  logic              last_done;
  int                busy_cnt;
  logic [ST_W-1:0]   last_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_cmd  <= '0;
      last_bank <= '0;
      last_done <= 1'b0;
    end else begin
      last_cmd  <= cmd_code;
      last_bank <= cmd_bank;
      last_done <= eng_done;
    end
  end

  always_comb begin
    busy_cnt = 0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (bank_state[ST_W*i +: ST_W] == BK_PROG || bank_state[ST_W*i +: ST_W] == BK_ERASE)
        busy_cnt++;
    last_tgt = bank_state[ST_W*last_bank +: ST_W];
  end

  // R3
  single_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) busy_cnt <= 1);

  // R2
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> resp_valid);

  // R2
  resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !cmd_valid |=> !resp_valid);

  // R6
  suspend_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_accept && last_cmd == CMD_SUSPEND) |->
      (last_tgt == BK_PSUSP || last_tgt == BK_ESUSP));

  // R7
  resume_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_accept && last_cmd == CMD_RESUME) |->
      (last_tgt == BK_PROG || last_tgt == BK_ERASE));

  // R11
  reject_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_accept && !last_done) |-> $stable(bank_state));

endmodule

bind bank_perm_ctrl bank_perm_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .cmd_bank    (cmd_bank),
  .eng_done    (eng_done),
  .resp_valid  (resp_valid),
  .resp_accept (resp_accept),
  .bank_state  (bank_state)
);

// File: tb/tb_bank_perm_ctrl.sv
module tb_bank_perm_ctrl;

  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_code = '0;
  logic [1:0]  cmd_bank = '0;
  logic        cmd_special = 1'b0;
  logic        eng_done = 1'b0;
  logic        resp_valid, resp_accept;
  logic [3*NB-1:0] bank_state;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural reference state
  int ms [NB];
  int mp_v, mp_b, mp_e, mspc;

  always #2.5 clk = ~clk;

  bank_perm_ctrl #(.NUM_BANKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_special(cmd_special), .eng_done(eng_done),
    .resp_valid(resp_valid), .resp_accept(resp_accept), .bank_state(bank_state)
  );

  function automatic int is_busy(int s);
    return (s == 1 || s == 2) ? 1 : 0;
  endfunction

  function automatic int model_ok(int c, int b, int sp);
    int any_busy = 0, any_susp = 0, any_ps = 0, spc, hit, setup;
    foreach (ms[i]) begin
      if (is_busy(ms[i]) != 0) any_busy = 1;
      if (ms[i] == 3 || ms[i] == 4) any_susp = 1;
      if (ms[i] == 3) any_ps = 1;
    end
    spc   = (c == 2 || c == 3 || (c == 0 && sp != 0)) ? 1 : 0;
    hit   = (mp_v != 0 && mp_b == b) ? 1 : 0;
    setup = (any_busy == 0 && mp_v == 0 && ms[b] == 0 && !(b == 0 && mspc != 0)) ? 1 : 0;
    case (c)
      0, 2, 3: return (is_busy(ms[b]) == 0 && hit == 0 && !(spc != 0 && is_busy(ms[0]) != 0)) ? 1 : 0;
      1: return 1;
      4: return (setup != 0 && any_ps == 0) ? 1 : 0;
      5: return (setup != 0 && any_susp == 0) ? 1 : 0;
      6: return hit;
      7: return is_busy(ms[b]);
      8: return ((ms[b] == 3 || ms[b] == 4) && any_busy == 0 && mp_v == 0) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_states(string tag);
    foreach (ms[i]) check({tag, " state"}, int'(bank_state[3*i +: 3]), ms[i]);
  endtask

  task automatic step(int v, int c, int b, int sp, int dn, string tag);
    int ok = 0;
    cmd_valid   = (v != 0);
    cmd_code    = 4'(c);
    cmd_bank    = 2'(b);
    cmd_special = (sp != 0);
    eng_done    = (dn != 0);
    if (dn != 0) foreach (ms[i]) if (is_busy(ms[i]) != 0) ms[i] = 0;
    if (v != 0) ok = model_ok(c, b, sp);
    @(posedge clk);
    if (ok != 0) begin
      case (c)
        4, 5: begin mp_v = 1; mp_b = b; mp_e = (c == 5) ? 1 : 0; end
        6: begin ms[b] = (mp_e != 0) ? 2 : 1; mp_v = 0; end
        7: ms[b] = (ms[b] == 2) ? 4 : 3;
        8: ms[b] = (ms[b] == 4) ? 2 : 1;
        default: ;
      endcase
      if (c == 2 || c == 3 || (c == 0 && sp != 0)) mspc = 1;
      else if (c == 0) mspc = 0;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    eng_done  = 1'b0;
    check({tag, " resp_valid"}, int'(resp_valid), v);
    if (v != 0) check({tag, " accept"}, int'(resp_accept), ok);
    check_states(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    foreach (ms[i]) ms[i] = 0;
    mp_v = 0; mp_b = 0; mp_e = 0; mspc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 resp_valid", int'(resp_valid), 0);
    check_states("R1");

    step(0, 4, 1, 0, 0, "R2 no strobe");
    step(1, 12, 1, 0, 0, "R2 illegal code");
    step(1, 0, 2, 0, 0, "R4 read idle");
    step(1, 6, 1, 0, 0, "R5 confirm no setup");
    step(1, 4, 1, 0, 0, "R5 prog setup");
    step(1, 0, 2, 0, 0, "R5 read other during setup");
    step(1, 0, 1, 0, 0, "R5 read setup bank");
    step(1, 5, 3, 0, 0, "R5 second setup");
    step(1, 6, 2, 0, 0, "R5 confirm wrong bank");
    step(1, 6, 1, 0, 0, "R5 confirm");
    step(1, 5, 3, 0, 0, "R3 erase while busy");
    step(1, 4, 2, 0, 0, "R3 prog while busy");
    step(1, 0, 1, 0, 0, "R4 read busy bank");
    step(1, 1, 1, 0, 0, "R4 status busy bank");
    step(1, 0, 0, 0, 0, "R4 read other bank");
    step(1, 2, 2, 0, 0, "R9 query param idle");
    step(1, 0, 2, 0, 0, "R10 clear special");
    step(1, 7, 2, 0, 0, "R6 suspend idle");
    step(1, 7, 1, 0, 0, "R6 suspend busy");
    step(1, 0, 1, 0, 0, "R6 read suspended");
    step(1, 4, 2, 0, 0, "R8 prog while prog-suspended");
    step(1, 8, 3, 0, 0, "R7 resume idle");
    step(1, 8, 1, 0, 0, "R7 resume");
    step(0, 0, 0, 0, 1, "R11 done");
    step(1, 5, 2, 0, 0, "R8 erase setup");
    step(1, 6, 2, 0, 0, "R8 erase confirm");
    step(1, 7, 2, 0, 0, "R6 suspend erase");
    step(1, 4, 3, 0, 0, "R8 prog during erase-suspend");
    step(1, 6, 3, 0, 0, "R8 confirm prog");
    step(1, 0, 1, 0, 0, "R8 read third bank");
    step(1, 8, 2, 0, 0, "R7 resume while other busy");
    step(1, 0, 3, 0, 1, "R11 done with read");
    step(1, 5, 1, 0, 0, "R8 erase while suspended");
    step(1, 8, 2, 0, 0, "R7 resume erase");
    step(0, 0, 0, 0, 1, "R11 done erase");
    step(1, 4, 0, 0, 0, "R9 param setup");
    step(1, 6, 0, 0, 0, "R9 param confirm");
    step(1, 2, 2, 0, 0, "R9 query");
    step(1, 3, 3, 0, 0, "R9 identifier");
    step(1, 0, 1, 1, 0, "R9 otp");
    step(1, 0, 1, 0, 0, "R9 plain read");
    step(0, 0, 0, 0, 1, "R11 done param");
    step(1, 3, 2, 0, 0, "R10 identifier");
    step(1, 4, 0, 0, 0, "R10 param setup blocked");
    step(1, 5, 0, 0, 0, "R10 param erase blocked");
    step(1, 0, 1, 0, 0, "R10 array read");
    step(1, 4, 0, 0, 0, "R10 param setup ok");

    for (int k = 0; k < 3000; k++) begin
      int rc, rv, rd;
      rv = ($urandom_range(0, 9) != 0) ? 1 : 0;
      rc = ($urandom_range(0, 3) == 0) ? 6 : int'($urandom_range(0, 9));
      rd = ($urandom_range(0, 7) == 0) ? 1 : 0;
      step(rv, rc, int'($urandom_range(0, NB - 1)), int'($urandom_range(0, 1)), rd, "R11 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule